// File: doc/BRIEF.md
# Convertible J-K/D Register Macrocell Bank

This block is a bank of registered output cells for a programmable logic sequencer. Each cell holds one positive-edge flip-flop. The flip-flop takes J and K product terms from the logic array, which sits outside this block. A fold-back control term forces K to the inverse of J, which turns the J-K flip-flop into a D-type on J while the design runs. Tying J and K to the same term gives a T (toggle) function.

A load-steering term lets a cell capture the level on its own pin, so the cell can serve as an input register or as a bus-interface register. A per-cell output-select line decides whether the pin is driven with the register value or left high-impedance. The register value always returns to the array on a feedback output.

Two dedicated product terms set or clear each register without a clock. A synchronous active-low reset, acting as the power-on event, puts every register in the set state. All control terms are vectors with one bit per cell, and every cell works on its own.

Top module: `jkd_macrocell`

## Requirements
- R1: A register changes only on a rising clock edge. A change on J, K, fold-back or load between edges leaves the register and `q_fb` unchanged until the next rising edge.
- R2: When fold-back and load are both low, the {J,K} pair decides the next state at a rising edge: 00 holds, 10 sets, 01 clears, 11 toggles.
- R3: When fold-back is high and load is low, the register takes the value of J at the rising edge, and K has no effect.
- R4: While `rst_n` is low at a rising edge, every register becomes 1. This overrides J, K, fold-back and load.
- R5: When load is high, the register takes the level present on its own pad at the rising edge. Load overrides both J-K and fold-back evaluation.
- R6: A high preset term forces the register to 1 and a high clear term forces it to 0, at once and with no clock edge. While either is held, the register ignores all clocked inputs. When both are high, clear wins and the register is 0.
- R7: When the output-select bit is 1, the pad carries the register value. When it is 0, the cell does not drive the pad, and the pad shows whatever an outside driver places on it.
- R8: `q_fb` shows the register value at all times, whatever the state of the output-select bit.
- R9: Each bit of every control vector acts only on the cell with the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; sets every register to 1 |
| j_term | input | CELLS | J product term, one bit per cell |
| k_term | input | CELLS | K product term, one bit per cell |
| fold_term | input | CELLS | Fold-back control; when high, the cell works as a D-type on J |
| load_term | input | CELLS | Load steering; when high, the cell captures its own pad level |
| preset_term | input | CELLS | Asynchronous set, active high |
| clear_term | input | CELLS | Asynchronous clear, active high; wins over preset |
| oe_sel | input | CELLS | Output select; 1 drives the pad with the register value |
| pad | inout | CELLS | Three-state cell pins |
| q_fb | output | CELLS | Register feedback to the array |

## Verification
Two pairs of functions can meet in the same cycle, and each needs its own test. First, a load request can arrive on the same edge as a toggle or fold-back request. The stimulus table applies load together with J=K=1, and then load together with fold-back. The result is judged correct only if the register holds the pad level rather than the J-K or D result. Second, the asynchronous terms can overlap with each other and with a clocked load. The bench raises preset between edges, then adds clear on one bit of the preset mask, then applies a load edge while both are still held. It checks that the result is zero on the cleared bit, one on the preset-only bit, and the loaded value on every other bit.

// File: rtl/jkd_pkg.sv
// Package jkd_pkg
// Shared types and helpers for the convertible register macrocell bank.
// Assumes: one bit per cell; priority of next-state sources is fixed here.
package jkd_pkg;

    // Source that supplies the next register value for one cell.
    typedef enum logic [1:0] {
        SRC_JK   = 2'd0,
        SRC_FOLD = 2'd1,
        SRC_PIN  = 2'd2
    } next_src_e;

    // Next state of a J-K flip-flop: hold, clear, set or toggle.
    function automatic logic jk_eval(input logic cur, input logic j, input logic k);
        logic res;
        case ({j, k})
            2'b00:   res = cur;
            2'b01:   res = 1'b0;
            2'b10:   res = 1'b1;
            default: res = ~cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/jkd_next_state.sv
// Module jkd_next_state
// Combinational next-state selection for CELLS register cells.
// Priority per cell: pad load, then fold-back (K forced to ~J), then plain J-K.
// Assumes: inputs are settled before the clock edge; no state is held here.
module jkd_next_state
    import jkd_pkg::*;
#(
    parameter int CELLS = 8
) (
    input  logic [CELLS-1:0] cur_q,
    input  logic [CELLS-1:0] j_in,
    input  logic [CELLS-1:0] k_in,
    input  logic [CELLS-1:0] fold_in,
    input  logic [CELLS-1:0] load_in,
    input  logic [CELLS-1:0] pin_in,
    output logic [CELLS-1:0] nxt
);

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        next_src_e src;
        logic      k_eff;

        // Pick the source that supplies this cell's next value.
        always_comb begin
            if (load_in[c])      src = SRC_PIN;
            else if (fold_in[c]) src = SRC_FOLD;
            else                 src = SRC_JK;
        end

        // Fold-back makes K the inverse of J, so the J-K rule becomes D on J.
        always_comb begin
            k_eff = (src == SRC_FOLD) ? ~j_in[c] : k_in[c];
        end

        // Form the next value from the selected source.
        always_comb begin
            case (src)
                SRC_PIN: nxt[c] = pin_in[c];
                default: nxt[c] = jk_eval(cur_q[c], j_in[c], k_eff);
            endcase
        end
    end

endmodule

// File: rtl/jkd_storage.sv
// Module jkd_storage
// One rising-edge register bit with asynchronous clear and preset and a
// synchronous active-low reset that loads the power-on value (set).
// Assumes: clear wins over preset; async terms are glitch-free product terms.
module jkd_storage #(
    parameter logic POWER_ON_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_clr,
    input  logic async_set,
    input  logic d,
    output logic q
);

    // Register with async clear/preset, then sync reset, then next value.
    always_ff @(posedge clk or posedge async_clr or posedge async_set) begin
        if (async_clr)      q <= 1'b0;
        else if (async_set) q <= 1'b1;
        else if (!rst_n)    q <= POWER_ON_VAL;
        else                q <= d;
    end

endmodule

// File: rtl/jkd_pad_driver.sv
// Module jkd_pad_driver
// Three-state pad drive for CELLS cells and the pad level returned for loading.
// Assumes: an outside driver owns each pad whose select bit is low.
module jkd_pad_driver #(
    parameter int CELLS = 8
) (
    input  logic [CELLS-1:0] drive_en,
    input  logic [CELLS-1:0] drive_val,
    inout  wire  [CELLS-1:0] pad,
    output logic [CELLS-1:0] pad_level
);

    for (genvar c = 0; c < CELLS; c++) begin : g_pad
        // Drive the pad only when selected; otherwise release it.
        assign pad[c] = drive_en[c] ? drive_val[c] : 1'bz;
    end

    // Return the resolved pad level to the load path.
    assign pad_level = pad;

endmodule

// File: rtl/jkd_macrocell.sv
// Module jkd_macrocell
// Bank of CELLS convertible J-K/D register macrocells. Each cell has a
// rising-edge register fed by J/K terms, fold-back to D mode, pad load
// steering, async preset/clear (clear wins), a three-state pad and feedback.
// Assumes: rst_n is synchronous, active low, and sets every register to 1.
module jkd_macrocell #(
    parameter int CELLS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CELLS-1:0] j_term,
    input  logic [CELLS-1:0] k_term,
    input  logic [CELLS-1:0] fold_term,
    input  logic [CELLS-1:0] load_term,
    input  logic [CELLS-1:0] preset_term,
    input  logic [CELLS-1:0] clear_term,
    input  logic [CELLS-1:0] oe_sel,
    inout  wire  [CELLS-1:0] pad,
    output logic [CELLS-1:0] q_fb
);

    localparam logic POWER_ON_VAL = 1'b1;

    logic [CELLS-1:0] reg_q;
    logic [CELLS-1:0] next_q;
    logic [CELLS-1:0] pad_level;

    jkd_next_state #(.CELLS(CELLS)) u_next (
        .cur_q   (reg_q),
        .j_in    (j_term),
        .k_in    (k_term),
        .fold_in (fold_term),
        .load_in (load_term),
        .pin_in  (pad_level),
        .nxt     (next_q)
    );

    for (genvar c = 0; c < CELLS; c++) begin : g_reg
        jkd_storage #(.POWER_ON_VAL(POWER_ON_VAL)) u_bit (
            .clk       (clk),
            .rst_n     (rst_n),
            .async_clr (clear_term[c]),
            .async_set (preset_term[c]),
            .d         (next_q[c]),
            .q         (reg_q[c])
        );

        // Sync reset sets the register unless an async term intervenes (R4).
        p_powerup_set_r4: assert property (@(posedge clk)
            (!rst_n && !clear_term[c] && !preset_term[c]) |=>
            (q_fb[c] || clear_term[c]));

        // Clear holds the register at 0 whatever else is active (R6).
        p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clear_term[c] |-> !q_fb[c]);

        // Preset alone holds the register at 1 (R6).
        p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (preset_term[c] && !clear_term[c]) |-> q_fb[c]);

        // Plain J-K with J=K=1 toggles the register (R2).
        p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_term[c] && !fold_term[c] && j_term[c] && k_term[c] &&
             !clear_term[c] && !preset_term[c]) |=>
            (clear_term[c] || preset_term[c] || (q_fb[c] != $past(q_fb[c]))));

        // Plain J-K with J=K=0 holds the register (R2).
        p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_term[c] && !fold_term[c] && !j_term[c] && !k_term[c] &&
             !clear_term[c] && !preset_term[c]) |=>
            (clear_term[c] || preset_term[c] || $stable(q_fb[c])));

        // Fold-back makes the register follow J (R3).
        p_fold_d_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (fold_term[c] && !load_term[c] && !clear_term[c] && !preset_term[c]) |=>
            (clear_term[c] || preset_term[c] || (q_fb[c] == $past(j_term[c]))));

        // Load captures the pad level ahead of J-K and fold-back (R5).
        p_load_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (load_term[c] && !clear_term[c] && !preset_term[c]) |=>
            (clear_term[c] || preset_term[c] || (q_fb[c] == $past(pad[c]))));

        // A selected pad carries the register value (R7).
        p_pad_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
            oe_sel[c] |-> (pad[c] == q_fb[c]));
    end

    jkd_pad_driver #(.CELLS(CELLS)) u_pad (
        .drive_en  (oe_sel),
        .drive_val (reg_q),
        .pad       (pad),
        .pad_level (pad_level)
    );

    // Feedback to the array is the register itself, independent of oe_sel (R8).
    assign q_fb = reg_q;

endmodule

// File: tb/jkd_macrocell_test.sv
// Bench for jkd_macrocell: vector table for clocked modes, then directed
// tests for reset, edge-only update, asynchronous terms and pad drive.
module jkd_macrocell_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] j_term = '1, k_term = '1, fold_term = '0, load_term = '0;
    logic [W-1:0] preset_term = '0, clear_term = '0, oe_sel = '0;
    logic [W-1:0] tb_val = '0;
    logic [W-1:0] tb_en = '1;
    wire  [W-1:0] pad;
    logic [W-1:0] q_fb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    for (genvar c = 0; c < W; c++) begin : g_tbpad
        assign pad[c] = tb_en[c] ? tb_val[c] : 1'bz;
    end

    jkd_macrocell #(.CELLS(W)) uut (
        .clk(clk), .rst_n(rst_n), .j_term(j_term), .k_term(k_term),
        .fold_term(fold_term), .load_term(load_term), .preset_term(preset_term),
        .clear_term(clear_term), .oe_sel(oe_sel), .pad(pad), .q_fb(q_fb)
    );

    always #5 clk = ~clk;

    // Row fields: load, fold, j, k, pad value, expected q after the edge.
    typedef struct packed {
        logic [W-1:0] ld;
        logic [W-1:0] fd;
        logic [W-1:0] j;
        logic [W-1:0] k;
        logic [W-1:0] pv;
        logic [W-1:0] exp_q;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF},  // R2 hold
        '{4'h0, 4'h0, 4'h0, 4'h5, 4'h0, 4'hA},  // R2 clear
        '{4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'hB},  // R2 set
        '{4'h0, 4'h0, 4'hF, 4'hF, 4'h0, 4'h4},  // R2 toggle
        '{4'h0, 4'h0, 4'h3, 4'h6, 4'h0, 4'h3},  // R2 R9 mixed per bit
        '{4'h0, 4'hF, 4'hA, 4'hA, 4'h0, 4'hA},  // R3 K ignored
        '{4'h0, 4'hF, 4'h5, 4'h0, 4'h0, 4'h5},  // R3 D on J
        '{4'h0, 4'h3, 4'h0, 4'hC, 4'h0, 4'h0},  // R3 R9 partial fold
        '{4'hF, 4'h0, 4'hF, 4'hF, 4'h9, 4'h9},  // R5 load beats toggle
        '{4'h6, 4'hF, 4'hF, 4'h0, 4'h0, 4'h9},  // R5 R9 partial load
        '{4'h0, 4'h0, 4'hF, 4'hF, 4'h0, 4'h6},  // R2 toggle again
        '{4'hF, 4'hF, 4'h3, 4'h0, 4'hC, 4'hC}   // R5 load beats fold
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #2;
    endtask

    initial begin
        // Reset with toggle requested: power-on set must win.
        repeat (3) @(posedge clk);
        #2;
        check("R4 reset sets all", q_fb, 4'hF);
        @(negedge clk);
        rst_n = 1'b1;
        j_term = '0;
        k_term = '0;

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            load_term = VECS[i].ld;
            fold_term = VECS[i].fd;
            j_term    = VECS[i].j;
            k_term    = VECS[i].k;
            tb_val    = VECS[i].pv;
            edge_wait();
            check($sformatf("R2/R3/R5 vector %0d", i), q_fb, VECS[i].exp_q);
        end

        // R1: input change between edges has no effect until the edge.
        @(negedge clk);
        load_term = '0; fold_term = '0; j_term = '0; k_term = '1;
        #3;
        check("R1 no change between edges", q_fb, 4'hC);
        edge_wait();
        check("R1 update on edge", q_fb, 4'h0);

        // R6: asynchronous preset, then clear overlap, then load while held.
        @(negedge clk);
        k_term = '0;
        preset_term = 4'h5;
        #1;
        check("R6 preset without clock", q_fb, 4'h5);
        @(posedge clk);
        @(negedge clk);
        clear_term = 4'h1;
        #1;
        check("R6 clear wins over preset", q_fb, 4'h4);
        @(negedge clk);
        load_term = '1;
        tb_val = 4'hA;
        edge_wait();
        check("R6 async terms beat load", q_fb, 4'hE);
        @(negedge clk);
        clear_term = '0; preset_term = '0; load_term = '0;
        edge_wait();
        check("R6 hold after release", q_fb, 4'hE);

        // R4: sync reset overrides load.
        @(negedge clk);
        rst_n = 1'b0; load_term = '1; tb_val = 4'h0;
        edge_wait();
        check("R4 reset beats load", q_fb, 4'hF);
        @(negedge clk);
        rst_n = 1'b1; load_term = '0;

        // R7/R8: pad carries q when selected; released pad shows outside level.
        @(negedge clk);
        tb_en = '0; oe_sel = '1;
        #1;
        check("R7 pad driven with q", pad, 4'hF);
        @(negedge clk);
        j_term = '1; k_term = '1;
        edge_wait();
        check("R7 pad follows toggled q", pad, 4'h0);
        @(negedge clk);
        j_term = '0; k_term = '0;
        oe_sel = '0; tb_val = 4'h5; tb_en = '1;
        #1;
        check("R7 released pad shows outside level", pad, 4'h5);
        check("R8 feedback with pad released", q_fb, 4'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule